// File: doc/BRIEF.md
# Sequenced Four-Tap FIR Engine

This block computes a four-tap finite impulse response filter with a single multiplier and a single adder. The filter is not laid out as parallel tap hardware. Each output is produced by a fixed register-transfer sequence that takes fourteen clock cycles.

The engine walks a sample memory with an input pointer that it increments before each use. It keeps the last four samples in a delay line and holds four signed coefficients. It builds the tap sum in an accumulator and stores each result through an output pointer, which is also incremented before use.

A controller sets the two base addresses, holds reset, loads the coefficients and then raises `run`. While `run` is high, one result leaves the engine every fourteen cycles. If `run` falls, the sample in progress still completes, and then the engine parks. It keeps its pointers and delay line, so a later `run` carries on with the next sample.

Top module: `fir_seq`

## Requirements
- R1: While `rst_n` is low, and afterwards as long as `run` has not been raised, `rd_en`, `wr_en` and `done` stay low. Reset clears the delay line to zero, so the first outputs after reset treat earlier samples as zero.
- R2: Each written word equals w1·x[i] + w2·x[i−1] + w3·x[i−2] + w4·x[i−3]. It is computed with signed 8-bit samples and coefficients and written as an 18-bit two's-complement value, with no overflow for any input.
- R3: While `run` stays high, `wr_en` is high for exactly one cycle in every 14, so consecutive writes are exactly 14 cycles apart.
- R4: The first read after reset uses address `base_in`. Each later read uses the previous read address plus one, modulo 2^AW.
- R5: The first write after reset uses address `base_out`. Each later write uses the previous write address plus one, modulo 2^AW.
- R6: The sample memory has one cycle of read latency. `rd_en` is high once per sample, nine cycles before the write of that sample's result, and `x1` takes `rd_data` in the cycle after `rd_en`.
- R7: `done` is high in exactly the cycles where `wr_en` is high.
- R8: If `run` falls, the current sample completes, and then no further reads or writes occur. The pointers and the delay line hold their values. Raising `run` again continues the address sequence and the filter history unchanged.
- R9: A coefficient is loaded when `coef_we` is high: `coef_sel` = 0 loads w1 (weight of the newest sample), 1 loads w2, 2 loads w3 and 3 loads w4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Keep processing samples while high |
| base_in | input | AW | First sample address, sampled during reset |
| base_out | input | AW | First result address, sampled during reset |
| coef_we | input | 1 | Coefficient write strobe |
| coef_sel | input | 2 | Coefficient index (0 = w1 … 3 = w4) |
| coef_data | input | DW | Signed coefficient value |
| rd_en | output | 1 | Sample memory read request |
| rd_addr | output | AW | Sample memory read address |
| rd_data | input | DW | Sample read data, valid one cycle after rd_en |
| wr_en | output | 1 | Result memory write strobe |
| wr_addr | output | AW | Result memory write address |
| wr_data | output | ACCW | Signed result |
| done | output | 1 | Pulses when a result is written |

## Verification
Several properties are checked on every cycle:
- the fixed nine-cycle gap between a read and its write;
- `x1` capturing read data one cycle after the request;
- the single-cycle width of each write;
- the pointer increments on their sequence steps;
- the pointers holding still while the engine is parked.

Only the bench's scenarios can show the following:
- the arithmetic result and the coefficient-to-tap mapping, through an impulse and a random stream checked against an independent sum;
- overflow safety at the most negative inputs;
- address wrap across the top of the address space;
- history being kept across a pause.

// File: rtl/fir_seq.sv
module fir_seq #(
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter int ACCW = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   run,
  input  logic [AW-1:0]          base_in,
  input  logic [AW-1:0]          base_out,
  input  logic                   coef_we,
  input  logic [1:0]             coef_sel,
  input  logic signed [DW-1:0]   coef_data,
  output logic                   rd_en,
  output logic [AW-1:0]          rd_addr,
  input  logic signed [DW-1:0]   rd_data,
  output logic                   wr_en,
  output logic [AW-1:0]          wr_addr,
  output logic signed [ACCW-1:0] wr_data,
  output logic                   done
);
  localparam int NTAP = 4;
  localparam int PW   = 2 * DW;
  localparam logic [3:0] S_RD   = 4'd4;
  localparam logic [3:0] S_LD   = 4'd5;
  localparam logic [3:0] S_LAST = 4'd13;

  logic [3:0]            step;
  logic [AW-1:0]         ax, ay;
  logic signed [DW-1:0]  xd [NTAP];
  logic signed [DW-1:0]  wc [NTAP];
  logic signed [ACCW-1:0] t1, t2;
  logic                  active;
  logic [1:0]            tap;
  logic signed [PW-1:0]  prod;
  logic signed [ACCW-1:0] prod_x, sum;

  assign active  = run || (step != 4'd0);
  assign rd_en   = active && (step == S_RD);
  assign rd_addr = ax;
  assign wr_en   = step == S_LAST;
  assign wr_addr = ay;
  assign wr_data = t1;
  assign done    = wr_en;

  always_comb begin
    case (step)
      4'd7:    tap = 2'd1;
      4'd9:    tap = 2'd2;
      4'd11:   tap = 2'd3;
      default: tap = 2'd0;
    endcase
  end

  assign prod   = wc[tap] * xd[tap];
  assign prod_x = ACCW'(prod);
  assign sum    = t1 + t2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAP; i++) wc[i] <= '0;
    end else if (coef_we) begin
      wc[coef_sel] <= coef_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      step <= '0;
      ax   <= base_in - 1'b1;
      ay   <= base_out - 1'b1;
      t1   <= '0;
      t2   <= '0;
      for (int i = 0; i < NTAP; i++) xd[i] <= '0;
    end else if (active) begin
      step <= (step == S_LAST) ? 4'd0 : step + 4'd1;
      case (step)
        4'd0:  xd[3] <= xd[2];
        4'd1:  xd[2] <= xd[1];
        4'd2:  xd[1] <= xd[0];
        4'd3:  ax    <= ax + 1'b1;
        S_LD:  xd[0] <= rd_data;
        4'd6:  t1    <= prod_x;
        4'd7, 4'd9, 4'd11: t2 <= prod_x;
        4'd8, 4'd10: t1 <= sum;
        4'd12: begin
          t1 <= sum;
          ay <= ay + 1'b1;
        end
        default: ;
      endcase
    end
  end

  p_rd_before_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rd_en, 9));

  p_x1_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_n && $past(rd_en) && $past(rst_n)) |=> xd[0] == $past(rd_data));

  p_single_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  p_ax_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && step == 4'd3) |=> ax == $past(ax) + 1'b1);

  p_ay_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step == 4'd12) |=> ay == $past(ay) + 1'b1);

  p_parked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && step == 4'd0) |=> $stable(ax) && $stable(ay) && !wr_en);

  p_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (wr_en && step == S_LAST));
endmodule

// File: tb/fir_seq_tb.sv
module fir_seq_tb;
  localparam int DW = 8, AW = 8, ACCW = 18;

  logic clk = 1'b0, rst_n = 1'b0, run = 1'b0;
  logic [AW-1:0] base_in = '0, base_out = '0;
  logic coef_we = 1'b0;
  logic [1:0] coef_sel = '0;
  logic signed [DW-1:0] coef_data = '0;
  logic rd_en, wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic signed [DW-1:0] rd_data;
  logic signed [ACCW-1:0] wr_data;

  always #10 clk = ~clk;

  fir_seq #(.DW(DW), .AW(AW), .ACCW(ACCW)) u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .base_in(base_in), .base_out(base_out),
    .coef_we(coef_we), .coef_sel(coef_sel), .coef_data(coef_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .done(done));

  logic signed [DW-1:0] mem [256];
  logic signed [DW-1:0] rq = '0;
  always @(posedge clk) if (rd_en) rq <= mem[rd_addr];
  assign rd_data = rq;

  int n_chk = 0, n_bad = 0;
  int cyc = 0, n_rd = 0, n_wr = 0, n_badrd = 0, last_wr_cyc = 0;
  int w_addr [64];
  int w_data [64];
  int w_cyc [64];
  int w_done [64];
  int rd_exp_addr = 0;
  int wt [4];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rst_n && rd_en) begin
      if (int'(rd_addr) != rd_exp_addr) n_badrd <= n_badrd + 1;
      rd_exp_addr <= (rd_exp_addr + 1) % 256;
      n_rd <= n_rd + 1;
    end
    if (rst_n && wr_en && n_wr < 64) begin
      w_addr[n_wr] <= int'(wr_addr);
      w_data[n_wr] <= int'(wr_data);
      w_cyc[n_wr]  <= cyc;
      w_done[n_wr] <= int'(done);
      n_wr <= n_wr + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int model(input int bin, input int k);
    int s = 0;
    for (int j = 0; j < 4; j++)
      if (k - j >= 0) s += wt[j] * int'(mem[(bin + k - j) % 256]);
    return s;
  endfunction

  task automatic do_reset(input int bi, input int bo);
    @(negedge clk);
    run = 1'b0; rst_n = 1'b0;
    base_in = AW'(bi); base_out = AW'(bo);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    n_rd = 0; n_wr = 0; n_badrd = 0; rd_exp_addr = bi;
  endtask

  task automatic load_coefs(input int a, input int b, input int c, input int d);
    wt[0] = a; wt[1] = b; wt[2] = c; wt[3] = d;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      coef_we = 1'b1; coef_sel = 2'(i); coef_data = DW'(wt[i]);
    end
    @(negedge clk);
    coef_we = 1'b0;
  endtask

  task automatic wait_writes(input int n);
    int guard = 0;
    while (n_wr < n && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
  endtask

  task automatic check_outputs(input int bi, input int bo, input int from, input int upto, input string tag);
    for (int k = from; k < upto; k++) begin
      check(w_data[k] == model(bi, k), {tag, " R2 data"}, w_data[k], model(bi, k));
      check(w_addr[k] == (bo + k) % 256, {tag, " R5 addr"}, w_addr[k], (bo + k) % 256);
      check(w_done[k] == 1, {tag, " R7 done"}, w_done[k], 1);
    end
  endtask

  task automatic t_reset_idle();
    do_reset(10, 100);
    repeat (20) @(negedge clk);
    check(rd_en == 0 && wr_en == 0 && done == 0, "R1 idle outputs", int'({rd_en, wr_en, done}), 0);
    check(n_rd == 0 && n_wr == 0, "R1 no access", n_rd + n_wr, 0);
  endtask

  task automatic t_impulse();
    for (int i = 0; i < 8; i++) mem[(10 + i) % 256] = (i == 0) ? 8'sd1 : 8'sd0;
    do_reset(10, 100);
    load_coefs(1, 2, 3, 4);
    run = 1'b1;
    wait_writes(6);
    run = 1'b0;
    repeat (30) @(negedge clk);
    check_outputs(10, 100, 0, 6, "impulse");
    check(w_data[0] == 1 && w_data[3] == 4, "R9 tap order", w_data[3], 4);
    check(n_badrd == 0, "R4 read addr", n_badrd, 0);
    for (int k = 1; k < 5; k++)
      check(w_cyc[k] - w_cyc[k-1] == 14, "R3 spacing", w_cyc[k] - w_cyc[k-1], 14);
  endtask

  task automatic t_random_pause();
    int stop_n, hold_wr, hold_rd;
    for (int i = 0; i < 64; i++) mem[(40 + i) % 256] = DW'($urandom);
    do_reset(40, 7);
    load_coefs(-37, 91, -128, 127);
    run = 1'b1;
    wait_writes(5);
    repeat (6) @(negedge clk);
    run = 1'b0;
    repeat (40) @(negedge clk);
    stop_n = n_wr;
    check(n_rd == n_wr, "R8 sample completes", n_rd, n_wr);
    hold_wr = n_wr; hold_rd = n_rd;
    repeat (30) @(negedge clk);
    check(n_wr == hold_wr && n_rd == hold_rd, "R8 parked", n_wr, hold_wr);
    run = 1'b1;
    wait_writes(stop_n + 6);
    run = 1'b0;
    repeat (30) @(negedge clk);
    check_outputs(40, 7, 0, n_wr, "random");
    check(n_badrd == 0, "R4 read addr after pause", n_badrd, 0);
  endtask

  task automatic t_extreme_wrap();
    for (int i = 0; i < 8; i++) mem[(252 + i) % 256] = -8'sd128;
    do_reset(252, 253);
    load_coefs(-128, -128, -128, -128);
    run = 1'b1;
    wait_writes(6);
    run = 1'b0;
    repeat (30) @(negedge clk);
    check_outputs(252, 253, 0, 6, "extreme");
    check(w_data[4] == 65536, "R2 no overflow", w_data[4], 65536);
    check(w_addr[3] == 0, "R5 wrap", w_addr[3], 0);
    check(n_badrd == 0, "R4 wrap read", n_badrd, 0);
  endtask

  initial begin
    fork
      begin
        t_reset_idle();
        t_impulse();
        t_random_pause();
        t_extreme_wrap();
      end
      begin
        repeat (100000) @(negedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule